// File: doc/BRIEF.md
# Two-Way Set-Associative Tag Lookup

This block holds the tag side of a small two-way set-associative cache. A 5-bit address is split into a 3-bit set index (bits [2:0]) and a 2-bit tag (bits [4:3]). Each of the eight sets has two ways. Each way has a tag and a valid flag. Each set also has one access bit that names a way. Both ways of the addressed set are compared at the same time. The hit flag, the hitting way and the replacement choice are combinational from the address in the cycle the lookup strobe is high.

When a strobed lookup misses, the tag is written into the chosen way at the next clock edge. The access bit then names the way that was touched: the hitting way on a hit, the filled way on a miss. An empty way is used before a valid way is replaced. When both ways are valid, the way named by the access bit is replaced. When a valid line is about to be overwritten, the block reports that line's tag so that a write-back controller can rebuild the address it must flush. Data storage and the memory side are outside this block.

There is no back-pressure. A lookup is taken on every cycle in which the strobe is high, and the block never stalls the requester. Lookup, hit, way and eviction pins are plain control and status signals.

Top module: `twoway_tag_lookup`

## Requirements
- R1: After reset every valid flag is clear. Every lookup then misses, and the replacement way for any set is way 0 (way codes: 0 = way 0, 1 = way 1).
- R2: The set index is address bits [2:0] and the tag is bits [4:3]. A fill in one set does not change the result of a lookup in any other set.
- R3: `lkp_hit` is high in the same cycle as the address when a valid way of the indexed set holds the address tag. `hit_way` then gives that way. On a miss `hit_way` reads 0.
- R4: A strobed lookup that misses writes the tag into the way given by `victim_way` at the next clock edge and marks that way valid. A lookup of the same address in the next cycle hits in that way.
- R5: On a miss, if way 0 of the set is invalid the victim is way 0. Otherwise, if way 1 is invalid, the victim is way 1.
- R6: On a miss with both ways valid, the victim is the way named by the set's access bit. A strobed hit sets the access bit to the hitting way.
- R7: After a miss fill, the set's access bit names the way just filled.
- R8: `evict_valid` is high only on a miss where both ways are valid. `evict_tag` then carries the tag stored in the victim way. Otherwise both read 0.
- R9: A cycle with `lkp_req` low changes no tag, valid flag or access bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid flags and access bits |
| lkp_req | input | 1 | Lookup strobe; when high, the lookup updates state at the edge |
| lkp_addr | input | 5 | Lookup address: [4:3] tag, [2:0] set index |
| lkp_hit | output | 1 | High when a valid way of the set matches the tag |
| hit_way | output | 1 | Way that matched; 0 on a miss |
| victim_way | output | 1 | Way that a miss fills |
| evict_valid | output | 1 | High when a miss overwrites a valid line |
| evict_tag | output | 2 | Tag of the line being overwritten; 0 when `evict_valid` is low |

## Verification
The assertions assume that `lkp_addr` is stable and known while `lkp_req` is sampled. They also assume that a lookup is never issued during reset. The fill-then-hit property further assumes that one lookup's address is compared with the next one only when both are strobed. The bench changes inputs only on the falling clock edge and holds them through the rising edge. It keeps `lkp_req` low for the whole reset, and it mixes strobed and idle cycles so that the idle-stability property is exercised as well.

// File: rtl/tlk_pkg.sv
package tlk_pkg;
  localparam int NUM_WAYS = 2;

  typedef enum logic {
    WAY_ZERO = 1'b0,
    WAY_ONE  = 1'b1
  } way_e;

  // Pick the way to fill: empty ways first, then the access bit.
  function automatic way_e pick_victim(input logic vld0, input logic vld1,
                                       input logic acc);
    way_e w;
    if (!vld0)      w = WAY_ZERO;
    else if (!vld1) w = WAY_ONE;
    else            w = way_e'(acc);
    return w;
  endfunction
endpackage

// File: rtl/tlk_way_store.sv
module tlk_way_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 2,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  output logic [SETS-1:0]  vld_all
);
  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < SETS; i++) tag_q[i] <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
      tag_q[wr_idx] <= wr_tag;
    end
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];
  assign vld_all = vld_q;
endmodule

// File: rtl/tlk_access_mem.sv
module tlk_access_mem #(
  parameter int IDX_W = 3,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             wr_en,
  input  logic             wr_bit,
  output logic             rd_bit,
  output logic [SETS-1:0]  bits_all
);
  logic [SETS-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (wr_en) acc_q[idx] <= wr_bit;
  end

  assign rd_bit   = acc_q[idx];
  assign bits_all = acc_q;
endmodule

// File: rtl/tlk_select.sv
module tlk_select
  import tlk_pkg::*;
#(
  parameter int TAG_W = 2
) (
  input  logic [NUM_WAYS-1:0]            way_vld,
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]               req_tag,
  input  logic                           acc_bit,
  output logic                           hit,
  output logic                           hit_way,
  output logic                           victim,
  output logic                           evict_vld,
  output logic [TAG_W-1:0]               evict_tag
);
  logic [NUM_WAYS-1:0] match;

  // Compare both ways of the set side by side.
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign match[w] = way_vld[w] && (way_tag[w] == req_tag);
  end

  always_comb begin
    hit       = |match;
    hit_way   = match[1];
    victim    = pick_victim(way_vld[0], way_vld[1], acc_bit);
    evict_vld = !hit && (&way_vld);
    evict_tag = evict_vld ? way_tag[victim] : '0;
  end
endmodule

// File: rtl/twoway_tag_lookup.sv
module twoway_tag_lookup
  import tlk_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 2,
  localparam int ADDR_W = IDX_W + TAG_W,
  localparam int SETS = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_req,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              lkp_hit,
  output logic              hit_way,
  output logic              victim_way,
  output logic              evict_valid,
  output logic [TAG_W-1:0]  evict_tag
);
  logic [IDX_W-1:0]               set_idx;
  logic [TAG_W-1:0]               req_tag;
  logic [NUM_WAYS-1:0]            rd_vld;
  logic [NUM_WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [NUM_WAYS*SETS-1:0]       way_vld;
  logic [SETS-1:0]                acc_bits;
  logic                           acc_rd;
  logic                           fill;

  assign set_idx = lkp_addr[IDX_W-1:0];
  assign req_tag = lkp_addr[IDX_W +: TAG_W];
  assign fill    = lkp_req && !lkp_hit;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tlk_way_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (set_idx),
      .wr_en   (fill && (victim_way == w[0])),
      .wr_idx  (set_idx),
      .wr_tag  (req_tag),
      .rd_vld  (rd_vld[w]),
      .rd_tag  (rd_tag[w]),
      .vld_all (way_vld[w*SETS +: SETS])
    );
  end

  tlk_access_mem #(.IDX_W(IDX_W)) acc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (set_idx),
    .wr_en    (lkp_req),
    .wr_bit   (lkp_hit ? hit_way : victim_way),
    .rd_bit   (acc_rd),
    .bits_all (acc_bits)
  );

  tlk_select #(.TAG_W(TAG_W)) sel_i (
    .way_vld   (rd_vld),
    .way_tag   (rd_tag),
    .req_tag   (req_tag),
    .acc_bit   (acc_rd),
    .hit       (lkp_hit),
    .hit_way   (hit_way),
    .victim    (victim_way),
    .evict_vld (evict_valid),
    .evict_tag (evict_tag)
  );
endmodule

// File: rtl/tlk_checker.sv
module tlk_checker #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 2,
  localparam int SETS = 1 << IDX_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lkp_req,
  input logic [IDX_W+TAG_W-1:0] lkp_addr,
  input logic                   lkp_hit,
  input logic                   hit_way,
  input logic                   victim_way,
  input logic                   evict_valid,
  input logic [2*SETS-1:0]      way_vld,
  input logic [SETS-1:0]        acc_bits
);
  logic [IDX_W-1:0] idx;
  logic             v0, v1;

  always_comb begin
    idx = lkp_addr[IDX_W-1:0];
    v0  = way_vld[idx];
    v1  = way_vld[SETS + idx];
  end

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (way_vld == '0));

  a_r4_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_req && $past(rst_n) && $past(lkp_req && !lkp_hit) && lkp_addr == $past(lkp_addr))
      |-> (lkp_hit && hit_way == $past(victim_way)));

  a_r5_empty_way_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!lkp_hit && (!v0 || !v1)) |-> (victim_way == !v0 ? 1'b0 : 1'b1));

  a_r6_hit_marks_access: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_req && lkp_hit) |=> (acc_bits[$past(idx)] == $past(hit_way)));

  a_r7_fill_marks_access: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_req && !lkp_hit) |=> (acc_bits[$past(idx)] == $past(victim_way)));

  a_r8_no_evict_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_hit |-> !evict_valid);

  a_r8_evict_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!lkp_hit && v0 && v1) |-> evict_valid);

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_req |=> ($stable(way_vld) && $stable(acc_bits)));
endmodule

bind twoway_tag_lookup tlk_checker #(.IDX_W(IDX_W), .TAG_W(TAG_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .lkp_req     (lkp_req),
  .lkp_addr    (lkp_addr),
  .lkp_hit     (lkp_hit),
  .hit_way     (hit_way),
  .victim_way  (victim_way),
  .evict_valid (evict_valid),
  .way_vld     (way_vld),
  .acc_bits    (acc_bits)
);

// File: tb/twoway_tag_lookup_tb_top.sv
`timescale 1ns/1ps
module twoway_tag_lookup_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lkp_req = 1'b0;
  logic [4:0] lkp_addr = '0;
  logic       lkp_hit, hit_way, victim_way, evict_valid;
  logic [1:0] evict_tag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Reference state computed from the requirements.
  bit       mv [8][2];
  bit [1:0] mt [8][2];
  bit       ma [8];

  always #10 clk = ~clk;

  twoway_tag_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .lkp_req(lkp_req), .lkp_addr(lkp_addr),
    .lkp_hit(lkp_hit), .hit_way(hit_way), .victim_way(victim_way),
    .evict_valid(evict_valid), .evict_tag(evict_tag)
  );

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic bit exp_victim(input int s);
    if (!mv[s][0]) return 1'b0;
    if (!mv[s][1]) return 1'b1;
    return ma[s];
  endfunction

  task automatic step(input bit req, input logic [4:0] a, input string ctx);
    int  s, t;
    bit  h0, h1, eh, ew, ev, eev;
    int  eet;
    @(negedge clk);
    lkp_req  = req;
    lkp_addr = a;
    #2;
    s   = int'(a[2:0]);
    t   = int'(a[4:3]);
    h0  = mv[s][0] && (mt[s][0] == t[1:0]);
    h1  = mv[s][1] && (mt[s][1] == t[1:0]);
    eh  = h0 || h1;
    ew  = h1;
    ev  = exp_victim(s);
    eev = !eh && mv[s][0] && mv[s][1];
    eet = eev ? int'(mt[s][ev]) : 0;
    chk({ctx, "/R3 hit"}, int'(lkp_hit), int'(eh));
    chk({ctx, "/R3 hit_way"}, int'(hit_way), int'(ew));
    if (!eh) chk({ctx, (mv[s][0] && mv[s][1]) ? "/R6 victim" : "/R5 victim"},
                 int'(victim_way), int'(ev));
    chk({ctx, "/R8 evict_valid"}, int'(evict_valid), int'(eev));
    chk({ctx, "/R8 evict_tag"}, int'(evict_tag), eet);
    @(posedge clk);
    if (req) begin
      if (eh) ma[s] = ew;
      else begin
        mv[s][ev] = 1'b1;
        mt[s][ev] = t[1:0];
        ma[s]     = ev;
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every set empty after reset; idle probes of all addresses
    for (int a = 0; a < 32; a++) step(1'b0, 5'(a), "R1");

    // R5/R4: fill way 0 then way 1 of set 1, each hitting right after
    step(1'b1, 5'h01, "R5");
    step(1'b1, 5'h01, "R4");
    step(1'b1, 5'h09, "R5");
    step(1'b1, 5'h09, "R4");
    // R7: access bit names way 1 (just filled); next miss replaces it
    step(1'b1, 5'h11, "R7");
    // R6: hit way 0 moves the access bit, next miss evicts way 0
    step(1'b1, 5'h01, "R6");
    step(1'b1, 5'h19, "R6");
    // R2: another set is still empty, same tag bits
    step(1'b1, 5'h02, "R2");
    step(1'b1, 5'h1A, "R2");
    step(1'b1, 5'h19, "R2");
    // R9: idle cycle with a missing address changes nothing
    step(1'b0, 5'h09, "R9");
    step(1'b0, 5'h09, "R9");
    step(1'b1, 5'h11, "R9");

    // Random mix of strobed and idle lookups
    for (int i = 0; i < 4000; i++) begin
      bit       rq;
      logic [4:0] ad;
      rq = ($urandom % 4) != 0;
      ad = 5'($urandom % 32);
      step(rq, ad, rq ? "rand" : "rand-R9");
    end

    @(negedge clk);
    lkp_req = 1'b0;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule